// File: doc/BRIEF.md
# Strap Latch and PLL Mode Selector

This block records two three-level board straps once, when the chip first leaves power-down after reset, and turns them into a serial-bus device address and a starting PLL operating mode. The strap pins arrive already resolved by the pad comparators into 2-bit level codes: 00 for low, 01 for mid and 10 for high. Code 11 cannot come from a correct comparator and is read as mid.

After capture, configuration-register fields can take over from the straps. A software mode field sets the active PLL mode only while its own enable bit is set. A software frequency field sets the output frequency only while its own enable bit is set. Otherwise the frequency stays at the 100 MHz default. The block also returns the captured mode code, which software reads back.

Before any capture the block reports that nothing is latched and holds the PLL off. Once captured, the values stay frozen until the next reset, no matter how often power-down is entered again.

Top module: `strap_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, the outputs are as follows: `straps_latched`=0, `pll_on`=0, `pll_bypass`=0, `freq_sel`=00, `smbus_addr`=0 and `mode_readback`=00.
- R2: Capture happens at the first clock edge after reset where `run_pin` is 1 and its value at the previous edge was 0. The pin's value is taken as 0 at reset. `straps_latched` reads 1 from that edge on.
- R3: Once captured, the straps are never captured again until reset. Later low-to-high transitions of `run_pin`, and strap changes, leave `smbus_addr` and `mode_readback` unchanged.
- R4: `smbus_addr` depends on the captured address level: low gives 7'h6B, mid gives 7'h6C and high gives 7'h6D. It is 0 while nothing is latched.
- R5: `mode_readback` gives the captured mode level as a PLL mode code. Low gives 00 (low bandwidth), mid gives 01 (bypass) and high gives 11 (high bandwidth).
- R6: A strap level code of 11 is handled as mid, both for the address and for the mode.
- R7: While `sw_mode_en`=0, `pll_mode` follows the captured strap mode one cycle later. While `sw_mode_en`=1, it follows `sw_mode` one cycle later.
- R8: A software mode value of 10 is applied as bypass (01).
- R9: Once latched, an active mode of 01 gives `pll_bypass`=1 and `pll_on`=0. Any other mode gives `pll_on`=1 and `pll_bypass`=0. Both flags follow the mode one cycle later.
- R10: While nothing is latched, `pll_on` and `pll_bypass` are both 0, whatever the override inputs hold.
- R11: While `sw_freq_en`=0, `freq_sel` becomes 00 (100 MHz) one cycle later. While `sw_freq_en`=1, a `sw_freq` of 00 (100 MHz), 01 (50 MHz) or 10 (125 MHz) is applied one cycle later.
- R12: With `sw_freq_en`=1, the reserved code `sw_freq`=11 leaves `freq_sel` at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_pin | input | 1 | Power-down pin level: 1 means run. Its first rise after reset triggers capture |
| addr_strap | input | 2 | Address strap level code (00 low, 01 mid, 10 high) |
| mode_strap | input | 2 | PLL mode strap level code (00 low, 01 mid, 10 high) |
| sw_mode_en | input | 1 | Gives the PLL mode to the software field |
| sw_mode | input | 2 | Software PLL mode (00 low bandwidth, 01 bypass, 11 high bandwidth) |
| sw_freq_en | input | 1 | Gives the frequency to the software field |
| sw_freq | input | 2 | Software frequency code (00 100 MHz, 01 50 MHz, 10 125 MHz, 11 reserved) |
| straps_latched | output | 1 | 1 once the straps have been captured |
| smbus_addr | output | 7 | Selected 7-bit serial-bus device address |
| mode_readback | output | 2 | Captured strap mode as a PLL mode code |
| pll_mode | output | 2 | Active PLL mode |
| pll_on | output | 1 | PLL enabled |
| pll_bypass | output | 1 | Outputs driven straight from the input clock |
| freq_sel | output | 2 | Active frequency code |

## Verification
A capture state that re-arms by mistake shows up as a change in `smbus_addr` or `mode_readback` within a few cycles of a second `run_pin` rise. A capture state that never arms leaves `straps_latched` low and both PLL flags at 0. A wrong override select or a wrong remap of the software value 10 shows up on `pll_mode` and the two PLL flags one cycle after the inputs change. A frequency register that fails to hold on the reserved code shows up on `freq_sel` one cycle after 11 is applied.

// File: rtl/strap_mode_pkg.sv
// Package: shared level codes, PLL mode codes and conversion helpers for the
// strap latch and mode selector. Assumes the pad comparators produce 2-bit levels.
package strap_mode_pkg;
    localparam int LVL_W  = 2;
    localparam int MODE_W = 2;
    localparam int FREQ_W = 2;

    localparam logic [LVL_W-1:0] LVL_LOW  = 2'b00;
    localparam logic [LVL_W-1:0] LVL_MID  = 2'b01;
    localparam logic [LVL_W-1:0] LVL_HIGH = 2'b10;

    localparam logic [MODE_W-1:0] PM_LOW_BW  = 2'b00;
    localparam logic [MODE_W-1:0] PM_BYPASS  = 2'b01;
    localparam logic [MODE_W-1:0] PM_SW_ODD  = 2'b10;
    localparam logic [MODE_W-1:0] PM_HIGH_BW = 2'b11;

    localparam logic [FREQ_W-1:0] FREQ_DEFAULT  = 2'b00;
    localparam logic [FREQ_W-1:0] FREQ_RESERVED = 2'b11;

    // Maps the impossible comparator code onto mid
    function automatic logic [LVL_W-1:0] lvl_clean(input logic [LVL_W-1:0] c);
        return (c == LVL_LOW || c == LVL_HIGH) ? c : LVL_MID;
    endfunction

    // Turns a cleaned strap level into the PLL mode code it selects
    function automatic logic [MODE_W-1:0] lvl_to_mode(input logic [LVL_W-1:0] c);
        case (c)
            LVL_LOW:  return PM_LOW_BW;
            LVL_HIGH: return PM_HIGH_BW;
            default:  return PM_BYPASS;
        endcase
    endfunction

    // Software mode 10 has no mode of its own and is applied as bypass
    function automatic logic [MODE_W-1:0] sw_to_mode(input logic [MODE_W-1:0] c);
        return (c == PM_SW_ODD) ? PM_BYPASS : c;
    endfunction
endpackage

// File: rtl/strap_capture.sv
// Module: strap_capture
// Detects the first low-to-high transition of the run pin after reset and
// freezes both strap levels at that edge. After that it ignores the pin until
// the next reset. Assumes the strap codes are stable around the capture edge.
module strap_capture
    import strap_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_pin,
    input  logic [LVL_W-1:0] addr_strap,
    input  logic [LVL_W-1:0] mode_strap,
    output logic             latched,
    output logic [LVL_W-1:0] addr_lvl,
    output logic [LVL_W-1:0] mode_lvl
);
    logic run_q;
    logic first_rise;

    // Rise of the run pin, seen only while still unlatched
    always_comb first_rise = run_pin && !run_q && !latched;

    // Pin history and the capture of both levels, held once taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            latched  <= 1'b0;
            addr_lvl <= LVL_LOW;
            mode_lvl <= LVL_LOW;
        end else begin
            run_q <= run_pin;
            if (first_rise) begin
                latched  <= 1'b1;
                addr_lvl <= lvl_clean(addr_strap);
                mode_lvl <= lvl_clean(mode_strap);
            end
        end
    end

    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        latched |=> latched); // R3
    AST_LEVELS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        latched |=> ($stable(addr_lvl) && $stable(mode_lvl))); // R3
    AST_CAPTURE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !latched |=> (latched -> $past(run_pin))); // R2
endmodule

// File: rtl/mode_select.sv
// Module: mode_select
// Chooses the active PLL mode from the strap or from the software field, and
// registers the mode together with the PLL enable and bypass flags. Assumes the
// strap mode input is already a PLL mode code.
module mode_select
    import strap_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latched,
    input  logic [MODE_W-1:0] strap_mode,
    input  logic              sw_en,
    input  logic [MODE_W-1:0] sw_mode,
    output logic [MODE_W-1:0] pll_mode,
    output logic              pll_on,
    output logic              pll_bypass
);
    logic [MODE_W-1:0] next_mode;

    // Override mux with the software remap applied
    always_comb next_mode = sw_en ? sw_to_mode(sw_mode) : strap_mode;

    // Registers the mode and its PLL flags, both held off until capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_mode   <= PM_LOW_BW;
            pll_on     <= 1'b0;
            pll_bypass <= 1'b0;
        end else begin
            pll_mode   <= next_mode;
            pll_on     <= latched && (next_mode != PM_BYPASS);
            pll_bypass <= latched && (next_mode == PM_BYPASS);
        end
    end

    AST_PLL_OFF_UNLATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !latched |=> (!pll_on && !pll_bypass)); // R10
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pll_on && pll_bypass)); // R9
    AST_SW_ODD_IS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && sw_en && sw_mode == PM_SW_ODD) |=> (pll_bypass && pll_mode == PM_BYPASS)); // R8
    AST_STRAP_FOLLOWED: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |=> (pll_mode == $past(strap_mode))); // R7
endmodule

// File: rtl/freq_select.sv
// Module: freq_select
// Holds the active frequency code. The software field drives it only while its
// enable is set. The reserved code keeps the previous selection.
module freq_select
    import strap_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_en,
    input  logic [FREQ_W-1:0] sw_freq,
    output logic [FREQ_W-1:0] freq_sel
);
    // Default, software load, or hold on the reserved code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_sel <= FREQ_DEFAULT;
        end else if (!sw_en) begin
            freq_sel <= FREQ_DEFAULT;
        end else if (sw_freq != FREQ_RESERVED) begin
            freq_sel <= sw_freq;
        end
    end

    AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && sw_freq == FREQ_RESERVED) |=> $stable(freq_sel)); // R12
    AST_FREQ_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |=> (freq_sel == FREQ_DEFAULT)); // R11
    AST_FREQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        freq_sel != FREQ_RESERVED); // R12
endmodule

// File: rtl/strap_mode_ctrl.sv
// Module: strap_mode_ctrl (top)
// Captures the address and mode straps once, derives the serial-bus address
// and the mode read-back code, and applies the software overrides for PLL mode
// and frequency. Assumes the inputs are synchronous to clk.
module strap_mode_ctrl
    import strap_mode_pkg::*;
#(
    parameter int               ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] ADDR_BASE = 7'h6B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_pin,
    input  logic [LVL_W-1:0]  addr_strap,
    input  logic [LVL_W-1:0]  mode_strap,
    input  logic              sw_mode_en,
    input  logic [MODE_W-1:0] sw_mode,
    input  logic              sw_freq_en,
    input  logic [FREQ_W-1:0] sw_freq,
    output logic              straps_latched,
    output logic [ADDR_W-1:0] smbus_addr,
    output logic [MODE_W-1:0] mode_readback,
    output logic [MODE_W-1:0] pll_mode,
    output logic              pll_on,
    output logic              pll_bypass,
    output logic [FREQ_W-1:0] freq_sel
);
    localparam int PAD_W = ADDR_W - LVL_W;

    logic [LVL_W-1:0] addr_lvl;
    logic [LVL_W-1:0] mode_lvl;

    strap_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_pin    (run_pin),
        .addr_strap (addr_strap),
        .mode_strap (mode_strap),
        .latched    (straps_latched),
        .addr_lvl   (addr_lvl),
        .mode_lvl   (mode_lvl)
    );

    // Address is the base plus the level step, zero until capture
    always_comb smbus_addr = straps_latched ? (ADDR_BASE + {{PAD_W{1'b0}}, addr_lvl}) : '0;

    // Captured mode level returned as a PLL mode code
    always_comb mode_readback = lvl_to_mode(mode_lvl);

    mode_select u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .latched    (straps_latched),
        .strap_mode (mode_readback),
        .sw_en      (sw_mode_en),
        .sw_mode    (sw_mode),
        .pll_mode   (pll_mode),
        .pll_on     (pll_on),
        .pll_bypass (pll_bypass)
    );

    freq_select u_freq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_en    (sw_freq_en),
        .sw_freq  (sw_freq),
        .freq_sel (freq_sel)
    );

    AST_ADDR_ZERO_UNLATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !straps_latched |-> (smbus_addr == '0)); // R4
    AST_READBACK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (straps_latched && $past(straps_latched)) |-> $stable(mode_readback)); // R3
endmodule

// File: tb/tb_strap_mode_ctrl.sv
module tb_strap_mode_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_pin = 1'b0;
    logic [1:0] addr_strap = 2'b00;
    logic [1:0] mode_strap = 2'b00;
    logic       sw_mode_en = 1'b0;
    logic [1:0] sw_mode = 2'b00;
    logic       sw_freq_en = 1'b0;
    logic [1:0] sw_freq = 2'b00;
    logic       straps_latched;
    logic [6:0] smbus_addr;
    logic [1:0] mode_readback;
    logic [1:0] pll_mode;
    logic       pll_on;
    logic       pll_bypass;
    logic [1:0] freq_sel;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .run_pin(run_pin),
        .addr_strap(addr_strap), .mode_strap(mode_strap),
        .sw_mode_en(sw_mode_en), .sw_mode(sw_mode),
        .sw_freq_en(sw_freq_en), .sw_freq(sw_freq),
        .straps_latched(straps_latched), .smbus_addr(smbus_addr),
        .mode_readback(mode_readback), .pll_mode(pll_mode),
        .pll_on(pll_on), .pll_bypass(pll_bypass), .freq_sel(freq_sel)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance n rising edges, then stop at the falling edge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; run_pin = 1'b0;
        sw_mode_en = 1'b0; sw_mode = 2'b00; sw_freq_en = 1'b0; sw_freq = 2'b00;
        step(3);
        rst_n = 1'b1;
    endtask

    // Reset values, during reset and right after it
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; step(2);
        chk("R1", "latched in reset", straps_latched, 0);
        chk("R1", "addr in reset", smbus_addr, 0);
        rst_n = 1'b1; step(1);
        chk("R1", "latched after reset", straps_latched, 0);
        chk("R1", "pll_on", pll_on, 0);
        chk("R1", "bypass", pll_bypass, 0);
        chk("R1", "freq", freq_sel, 0);
        chk("R1", "readback", mode_readback, 0);
    endtask

    // Capture one strap pair and check address, read-back and PLL flags
    task automatic t_capture(input logic [1:0] a, input logic [1:0] m,
                             input int exp_addr, input int exp_mode);
        do_reset();
        addr_strap = a; mode_strap = m;
        step(2);
        chk("R2", "no capture before rise", straps_latched, 0);
        run_pin = 1'b1;
        step(1);
        chk("R2", "latched after rise", straps_latched, 1);
        step(2);
        chk((a == 2'b11) ? "R6" : "R4", "address", smbus_addr, exp_addr);
        chk((m == 2'b11) ? "R6" : "R5", "readback", mode_readback, exp_mode);
        chk("R7", "mode from strap", pll_mode, exp_mode);
        chk("R9", "bypass flag", pll_bypass, (exp_mode == 1) ? 1 : 0);
        chk("R9", "pll_on flag", pll_on, (exp_mode == 1) ? 0 : 1);
    endtask

    // Second and third power-down cycles with changed straps must not capture again
    task automatic t_recapture();
        t_capture(2'b01, 2'b01, 7'h6C, 1);
        for (int i = 0; i < 2; i++) begin
            run_pin = 1'b0;
            addr_strap = (i == 0) ? 2'b10 : 2'b00;
            mode_strap = (i == 0) ? 2'b10 : 2'b00;
            step(3);
            run_pin = 1'b1;
            step(3);
            chk("R3", "address kept", smbus_addr, 7'h6C);
            chk("R3", "readback kept", mode_readback, 1);
            chk("R3", "still latched", straps_latched, 1);
        end
    endtask

    // PLL held off with overrides active while unlatched
    task automatic t_unlatched();
        do_reset();
        sw_mode_en = 1'b1; sw_mode = 2'b11;
        step(4);
        chk("R10", "pll_on unlatched", pll_on, 0);
        sw_mode = 2'b01; step(2);
        chk("R10", "bypass unlatched", pll_bypass, 0);
        chk("R4", "address unlatched", smbus_addr, 0);
    endtask

    // Software mode override and the remap of value 10
    task automatic t_sw_mode();
        t_capture(2'b00, 2'b00, 7'h6B, 0);
        sw_mode_en = 1'b1; sw_mode = 2'b11;
        step(1);
        chk("R7", "sw high bw", pll_mode, 3);
        chk("R9", "pll_on high bw", pll_on, 1);
        sw_mode = 2'b10; step(1);
        chk("R8", "sw 10 mode", pll_mode, 1);
        chk("R8", "sw 10 bypass", pll_bypass, 1);
        chk("R9", "pll off in bypass", pll_on, 0);
        sw_mode = 2'b01; step(1);
        chk("R7", "sw bypass", pll_mode, 1);
        sw_mode = 2'b00; step(1);
        chk("R7", "sw low bw", pll_mode, 0);
        chk("R9", "pll on low bw", pll_on, 1);
        sw_mode = 2'b11; sw_mode_en = 1'b0; step(1);
        chk("R7", "enable off back to strap", pll_mode, 0);
    endtask

    // Frequency default, software codes and hold on the reserved code
    task automatic t_freq();
        do_reset();
        sw_freq = 2'b10; step(2);
        chk("R11", "disabled stays default", freq_sel, 0);
        sw_freq_en = 1'b1; step(1);
        chk("R11", "125 MHz", freq_sel, 2);
        sw_freq = 2'b11; step(2);
        chk("R12", "reserved holds 125", freq_sel, 2);
        sw_freq = 2'b01; step(1);
        chk("R11", "50 MHz", freq_sel, 1);
        sw_freq = 2'b11; step(1);
        chk("R12", "reserved holds 50", freq_sel, 1);
        sw_freq = 2'b00; step(1);
        chk("R11", "100 MHz", freq_sel, 0);
        sw_freq = 2'b10; step(1);
        sw_freq_en = 1'b0; step(1);
        chk("R11", "disable back to default", freq_sel, 0);
    endtask

    initial begin
        t_reset();
        t_capture(2'b00, 2'b00, 7'h6B, 0);
        t_capture(2'b01, 2'b01, 7'h6C, 1);
        t_capture(2'b10, 2'b10, 7'h6D, 3);
        t_capture(2'b11, 2'b11, 7'h6C, 1);
        t_recapture();
        t_unlatched();
        t_sw_mode();
        t_freq();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule